// File: doc/BRIEF.md
# Four-Error Correction Sequencer

After a 512-byte sector has been read through an error-locator engine, this block carries out the correction pass. A one-cycle start pulse arms it. It then waits for the engine to present its syndrome. A syndrome that is zero in every bit ends the pass at once with nothing corrected. A nonzero syndrome makes the block pulse a kick to the engine so that the engine begins computing error locations. The block then follows the engine's 4-bit state field until the error addresses are ready or the engine declares the sector uncorrectable.

When the addresses are ready, the block reads up to four address/value pairs from two address words and two value words. Each address is converted from the engine's reversed numbering into a byte offset, and any error that falls outside the data area is dropped. Each remaining error is XORed into the sector buffer through a read-modify-write. The pass ends with a single done pulse that carries a signed result: the number of bytes changed, or -1 when the sector cannot be corrected.

Right after the kick, the engine may still show a stale "ready" code. The block therefore ignores every state below 4 until the engine has reported busy at least once, or until a bounded wait runs out.

Top module: `ecc_fix_seq`

## Requirements
- R1: When `start_i` has been seen and `syn_valid_i` arrives with `syn_i` equal to zero, the block pulses `done_o` with `result_o` = 0, does not pulse `calc_start_o`, and makes no buffer access.
- R2: When the syndrome is nonzero, `calc_start_o` is pulsed high for exactly one cycle, once per pass.
- R3: After the kick, any state below 4 is ignored until the state reaches 4 or more. If the state never reaches 4, the block decodes whatever state is present once TIMEOUT cycles have passed.
- R4: A state of 0 during polling ends the pass with `result_o` = 0 and no buffer writes.
- R5: A state of 1 during polling ends the pass with `result_o` = -1 and no buffer writes.
- R6: States 4 to 15 keep the block polling, with no done pulse and no buffer access.
- R7: States 2 and 3 mean the addresses are ready. The number of errors processed is `err_cnt_i` + 1.
- R8: Errors 0 and 1 come from `addr_a_i`/`val_a_i`, and errors 2 and 3 from `addr_b_i`/`val_b_i`. An even-numbered error uses bits 15:0 of its word and an odd-numbered error uses bits 31:16.
- R9: The byte offset is 519 minus the low 10 bits of the address half. The correction is applied only when that offset lies in 0..511, and the low 8 bits of the value half are XORed into that byte.
- R10: `done_o` is a one-cycle pulse. `result_o` at the pulse equals the number of corrections actually applied.
- R11: Each correction takes two cycles: `buf_re_o` with the offset, then `buf_we_o` on the same offset with `buf_rdata_i` XOR the value. Corrections are applied in error order, so repeated offsets accumulate.
- R12: While reset is held, `done_o`, `calc_start_o`, `buf_re_o` and `buf_we_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a correction pass |
| syn_valid_i | input | 1 | Syndrome is available |
| syn_i | input | SYN_W | Syndrome words, concatenated |
| calc_start_o | output | 1 | Kicks the engine's address calculation |
| eng_state_i | input | 4 | Engine state field |
| err_cnt_i | input | 2 | Error count minus one |
| addr_a_i | input | 32 | Error addresses 0 (low half) and 1 (high half) |
| addr_b_i | input | 32 | Error addresses 2 (low half) and 3 (high half) |
| val_a_i | input | 32 | Error values 0 and 1 |
| val_b_i | input | 32 | Error values 2 and 3 |
| buf_re_o | output | 1 | Buffer read request |
| buf_we_o | output | 1 | Buffer write strobe |
| buf_addr_o | output | AW | Buffer byte offset |
| buf_wdata_o | output | 8 | Corrected byte |
| buf_rdata_i | input | 8 | Buffer read data, one cycle after the request |
| done_o | output | 1 | Pass complete pulse |
| result_o | output | RES_W | Signed correction count, or -1 |

## Verification
The bench's engine stub keeps a stale "ready" state, together with harmful address and value words, on its outputs for several cycles after the kick. A sequencer that acts before seeing the busy state would therefore write bytes that should not change. One case never reports busy at all, which tests the bounded wait: a design without it hangs. Addresses just outside the data area (remapped offsets 512 and negative) and address halves with high bits set are included; a wrong remap or a missing mask shows up as stray writes or a wrong count. A repeated offset, an error count of one with a valid-looking unused upper half, and the fail state with valid addresses complete the set. Each of these would expose reads of stale data, an off-by-one in the count, or writes on a failed sector.

// File: rtl/ecc_fix_pkg.sv
package ecc_fix_pkg;
  localparam int WORD_W = 32;
  localparam int HALF_W = 16;
  localparam int BYTE_W = 8;

  localparam logic [3:0] ST_CLEAN    = 4'd0;
  localparam logic [3:0] ST_FAIL     = 4'd1;
  localparam logic [3:0] ST_RDY_LO   = 4'd2;
  localparam logic [3:0] ST_RDY_HI   = 4'd3;
  localparam logic [3:0] ST_BUSY_MIN = 4'd4;

  typedef enum logic [2:0] {
    S_IDLE, S_SYN, S_KICK, S_ARM, S_POLL, S_PICK, S_WR
  } seq_st_e;
endpackage

// File: rtl/ecc_err_pick.sv
module ecc_err_pick import ecc_fix_pkg::*; #(
  parameter int SECT_BYTES = 512,
  parameter int EA_W       = 10,
  parameter int AW         = $clog2(SECT_BYTES)
) (
  input  logic [1:0]        idx_i,
  input  logic [WORD_W-1:0] addr_a_i,
  input  logic [WORD_W-1:0] addr_b_i,
  input  logic [WORD_W-1:0] val_a_i,
  input  logic [WORD_W-1:0] val_b_i,
  output logic [AW-1:0]     ofs_o,
  output logic              hit_o,
  output logic [BYTE_W-1:0] val_o
);
  localparam int OFS_BASE = SECT_BYTES + 7;
  localparam int DW       = EA_W + 2;

  logic [WORD_W-1:0] a_word, v_word;
  logic [HALF_W-1:0] a_half, v_half;
  logic [EA_W-1:0]   ea;
  logic [DW-1:0]     diff;
  logic              unused_bits;

  always_comb begin
    a_word = idx_i[1] ? addr_b_i : addr_a_i;
    v_word = idx_i[1] ? val_b_i  : val_a_i;
    a_half = idx_i[0] ? a_word[WORD_W-1:HALF_W] : a_word[HALF_W-1:0];
    v_half = idx_i[0] ? v_word[WORD_W-1:HALF_W] : v_word[HALF_W-1:0];
    ea     = a_half[EA_W-1:0];
    // reversed numbering; negatives wrap far above the sector size
    diff   = DW'(OFS_BASE) - DW'(ea);
    hit_o  = diff < DW'(SECT_BYTES);
    ofs_o  = diff[AW-1:0];
    val_o  = v_half[BYTE_W-1:0];
  end

  assign unused_bits = ^{a_half[HALF_W-1:EA_W], v_half[HALF_W-1:BYTE_W], diff[DW-1:AW]};
endmodule

// File: rtl/ecc_wait_timer.sv
module ecc_wait_timer #(
  parameter int TIMEOUT = 1024,
  parameter int TW      = $clog2(TIMEOUT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expired_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (!run_i)       cnt_q <= '0;
    else if (!expired_o)   cnt_q <= cnt_q + TW'(1);
  end

  assign expired_o = run_i && (cnt_q >= TW'(TIMEOUT - 1));
endmodule

// File: rtl/ecc_fix_seq.sv
module ecc_fix_seq import ecc_fix_pkg::*; #(
  parameter int SECT_BYTES = 512,
  parameter int EA_W       = 10,
  parameter int SYN_W      = 128,
  parameter int TIMEOUT    = 1024,
  parameter int RES_W      = 4,
  localparam int AW        = $clog2(SECT_BYTES)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic                    syn_valid_i,
  input  logic [SYN_W-1:0]        syn_i,
  output logic                    calc_start_o,
  input  logic [3:0]              eng_state_i,
  input  logic [1:0]              err_cnt_i,
  input  logic [WORD_W-1:0]       addr_a_i,
  input  logic [WORD_W-1:0]       addr_b_i,
  input  logic [WORD_W-1:0]       val_a_i,
  input  logic [WORD_W-1:0]       val_b_i,
  output logic                    buf_re_o,
  output logic                    buf_we_o,
  output logic [AW-1:0]           buf_addr_o,
  output logic [BYTE_W-1:0]       buf_wdata_o,
  input  logic [BYTE_W-1:0]       buf_rdata_i,
  output logic                    done_o,
  output logic signed [RES_W-1:0] result_o
);
  seq_st_e           st_q;
  logic [1:0]        idx_q, last_q;
  logic [2:0]        fixes_q;
  logic [AW-1:0]     ofs_q;
  logic [BYTE_W-1:0] val_q;
  logic              done_q;
  logic [RES_W-1:0]  res_q;

  logic [AW-1:0]     pick_ofs;
  logic              pick_hit;
  logic [BYTE_W-1:0] pick_val;
  logic              tmo_hit;

  ecc_err_pick #(.SECT_BYTES(SECT_BYTES), .EA_W(EA_W), .AW(AW)) u_pick (
    .idx_i    (idx_q),
    .addr_a_i (addr_a_i),
    .addr_b_i (addr_b_i),
    .val_a_i  (val_a_i),
    .val_b_i  (val_b_i),
    .ofs_o    (pick_ofs),
    .hit_o    (pick_hit),
    .val_o    (pick_val)
  );

  ecc_wait_timer #(.TIMEOUT(TIMEOUT)) u_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (st_q == S_ARM),
    .expired_o (tmo_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      idx_q   <= '0;
      last_q  <= '0;
      fixes_q <= '0;
      ofs_q   <= '0;
      val_q   <= '0;
      done_q  <= 1'b0;
      res_q   <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        S_IDLE: if (start_i) st_q <= S_SYN;
        S_SYN: begin
          if (syn_valid_i) begin
            if (syn_i == '0) begin
              done_q <= 1'b1;
              res_q  <= '0;
              st_q   <= S_IDLE;
            end else begin
              st_q <= S_KICK;
            end
          end
        end
        S_KICK: st_q <= S_ARM;
        // stale low states are ignored until busy is seen or the wait runs out
        S_ARM: if (eng_state_i >= ST_BUSY_MIN || tmo_hit) st_q <= S_POLL;
        S_POLL: begin
          case (eng_state_i)
            ST_CLEAN: begin
              done_q <= 1'b1;
              res_q  <= '0;
              st_q   <= S_IDLE;
            end
            ST_FAIL: begin
              done_q <= 1'b1;
              res_q  <= '1;
              st_q   <= S_IDLE;
            end
            ST_RDY_LO, ST_RDY_HI: begin
              last_q  <= err_cnt_i;
              idx_q   <= '0;
              fixes_q <= '0;
              st_q    <= S_PICK;
            end
            default: ;
          endcase
        end
        S_PICK: begin
          if (pick_hit) begin
            ofs_q <= pick_ofs;
            val_q <= pick_val;
            st_q  <= S_WR;
          end else if (idx_q == last_q) begin
            done_q <= 1'b1;
            res_q  <= RES_W'(fixes_q);
            st_q   <= S_IDLE;
          end else begin
            idx_q <= idx_q + 2'd1;
          end
        end
        S_WR: begin
          fixes_q <= fixes_q + 3'd1;
          if (idx_q == last_q) begin
            done_q <= 1'b1;
            res_q  <= RES_W'(fixes_q + 3'd1);
            st_q   <= S_IDLE;
          end else begin
            idx_q <= idx_q + 2'd1;
            st_q  <= S_PICK;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign calc_start_o = (st_q == S_KICK);
  assign buf_re_o     = (st_q == S_PICK) && pick_hit;
  assign buf_we_o     = (st_q == S_WR);
  assign buf_addr_o   = (st_q == S_WR) ? ofs_q : pick_ofs;
  assign buf_wdata_o  = buf_rdata_i ^ val_q;
  assign done_o       = done_q;
  assign result_o     = res_q;
endmodule

// File: rtl/ecc_fix_seq_chk.sv
module ecc_fix_seq_chk #(
  parameter int AW    = 9,
  parameter int RES_W = 4
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    calc_start_o,
  input logic                    buf_re_o,
  input logic                    buf_we_o,
  input logic [AW-1:0]           buf_addr_o,
  input logic                    done_o,
  input logic signed [RES_W-1:0] result_o
);
  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R2
  kick_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    calc_start_o |=> !calc_start_o);
  // R11
  rmw_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_re_o |=> buf_we_o);
  // R11
  rmw_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_we_o |-> ($past(buf_re_o) && buf_addr_o == $past(buf_addr_o)));
  // R1
  done_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!buf_re_o && !buf_we_o && !calc_start_o));
  // R5
  fail_nowrite_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && result_o == -1) |-> !$past(buf_we_o));
endmodule

bind ecc_fix_seq ecc_fix_seq_chk #(.AW(AW), .RES_W(RES_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .calc_start_o (calc_start_o),
  .buf_re_o     (buf_re_o),
  .buf_we_o     (buf_we_o),
  .buf_addr_o   (buf_addr_o),
  .done_o       (done_o),
  .result_o     (result_o)
);

// File: tb/ecc_fix_seq_test.sv
module ecc_fix_seq_test;
  localparam int TMO = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0, syn_valid = 1'b0;
  logic [127:0] syn = '0;
  logic         calc;
  logic [3:0]   est = 4'd3;
  logic [1:0]   ecnt = 2'd3;
  logic [31:0]  a_a = 32'h00F0_00F0, a_b = 32'h00F0_00F0;
  logic [31:0]  v_a = 32'h00FF_00FF, v_b = 32'h00FF_00FF;
  logic         re, we, done;
  logic [8:0]   baddr;
  logic [7:0]   wdata, rdata;
  logic signed [3:0] res;

  always #5 clk = ~clk;

  ecc_fix_seq #(.TIMEOUT(TMO)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .syn_valid_i(syn_valid),
    .syn_i(syn), .calc_start_o(calc), .eng_state_i(est), .err_cnt_i(ecnt),
    .addr_a_i(a_a), .addr_b_i(a_b), .val_a_i(v_a), .val_b_i(v_b),
    .buf_re_o(re), .buf_we_o(we), .buf_addr_o(baddr), .buf_wdata_o(wdata),
    .buf_rdata_i(rdata), .done_o(done), .result_o(res)
  );

  logic [7:0] mem [512];
  logic [7:0] gold [512];
  int checks = 0, errors = 0;
  int n_done = 0, n_calc = 0, last_res = 0;
  int expq [$];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 512; i++) mem[i] <= 8'(i * 7 + 3);
      rdata <= '0;
    end else begin
      if (re) rdata <= mem[baddr];
      if (we) mem[baddr] <= wdata;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // per-clock comparison against the model's write queue
  always @(negedge clk) begin
    if (rst_n) begin
      if (we) begin
        if (expq.size() == 0) chk(0, "R9", "unexpected write at offset", int'(baddr), -1);
        else begin
          int e;
          e = expq.pop_front();
          chk(int'(baddr) == e / 256, "R11", "write offset", int'(baddr), e / 256);
          chk(int'(wdata) == e % 256, "R11", "write data", int'(wdata), e % 256);
        end
      end
      if (done) begin n_done++; last_res = int'(res); end
      if (calc) n_calc++;
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      chk(0, "R10", "watchdog expired", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic garbage();
    est = 4'd3; ecnt = 2'd3;
    a_a = 32'h00F0_00F0; a_b = 32'h00F0_00F0;
    v_a = 32'h00FF_00FF; v_b = 32'h00FF_00FF;
  endtask

  task automatic run_case(input string req, input logic [127:0] s, input bit tmo,
                          input int early, input int busy, input int fst, input int cnt,
                          input logic [31:0] aa, input logic [31:0] ab,
                          input logic [31:0] va, input logic [31:0] vb);
    int exp_res, w, mism;
    exp_res = 0;
    if (s != '0 && fst == 1) exp_res = -1;
    if (s != '0 && fst >= 2) begin
      for (int i = 0; i <= cnt; i++) begin
        logic [31:0] aw, vw;
        logic [15:0] ah, vh;
        int off;
        aw = (i < 2) ? aa : ab;
        vw = (i < 2) ? va : vb;
        ah = (i % 2 == 1) ? aw[31:16] : aw[15:0];
        vh = (i % 2 == 1) ? vw[31:16] : vw[15:0];
        off = 519 - int'(ah & 16'h03FF);
        if (off >= 0 && off < 512) begin
          gold[off] = gold[off] ^ vh[7:0];
          expq.push_back(off * 256 + int'(gold[off]));
          exp_res++;
        end
      end
    end
    n_done = 0; n_calc = 0;
    garbage();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0; syn = s;
    @(negedge clk); syn_valid = 1'b1;
    if (s != '0) begin
      w = 0;
      while (!calc && w < 50) begin @(negedge clk); w++; end
      if (tmo) begin
        est = 4'(fst); ecnt = 2'(cnt); a_a = aa; a_b = ab; v_a = va; v_b = vb;
      end else begin
        repeat (early) @(negedge clk);
        est = 4'd9;
        repeat (busy) @(negedge clk);
        chk(n_done == 0, "R6", "done while busy", n_done, 0);
        est = 4'(fst); ecnt = 2'(cnt); a_a = aa; a_b = ab; v_a = va; v_b = vb;
      end
    end
    w = 0;
    while (n_done == 0 && w < 300) begin @(negedge clk); w++; end
    repeat (3) @(negedge clk);
    syn_valid = 1'b0;
    garbage();
    chk(n_done == 1, req, "done pulses", n_done, 1);
    chk(last_res == exp_res, req, "result", last_res, exp_res);
    chk(expq.size() == 0, req, "missing writes", expq.size(), 0);
    chk(n_calc == ((s != '0) ? 1 : 0), "R2", "kick pulses", n_calc, (s != '0) ? 1 : 0);
    mism = 0;
    for (int i = 0; i < 512; i++) if (mem[i] != gold[i]) mism++;
    chk(mism == 0, req, "buffer bytes differing", mism, 0);
    expq.delete();
  endtask

  initial begin
    for (int i = 0; i < 512; i++) gold[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    // R12 reset outputs
    chk(!done && !we && !re && !calc, "R12", "outputs during reset",
        int'({done, we, re, calc}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 zero syndrome
    run_case("R1", '0, 0, 0, 0, 2, 3, 32'h0064_0013, 32'h0008_0207, 32'h0011_0022, 32'h0033_0044);
    // R3 R7 R8 stale ready ignored; four errors, masked high address bits
    run_case("R8", 128'h1, 0, 3, 5, 2, 3,
             32'h0064_FC13, 32'h0008_0207, 32'h11A5_7E3C, 32'h2281_0011);
    // R9 out-of-range offsets dropped (ea 7 -> 512, ea 600 -> negative)
    run_case("R9", 128'h5 << 100, 0, 2, 2, 3, 2,
             32'h0258_0007, 32'h0000_000C, 32'h0055_0066, 32'h0000_0077);
    // R4 clean state
    run_case("R4", 128'h3, 0, 1, 3, 0, 3,
             32'h0064_0013, 32'h0008_0207, 32'h0011_0022, 32'h0033_0044);
    // R5 failure, valid addresses must not be written
    run_case("R5", 128'h3, 0, 2, 2, 1, 3,
             32'h0064_0013, 32'h0008_0207, 32'h0011_0022, 32'h0033_0044);
    // R3 bounded wait: engine never reports busy
    run_case("R3", 128'h7, 1, 0, 0, 3, 1,
             32'h0100_0050, 32'h0000_0000, 32'h0099_0042, 32'h0000_0000);
    // R11 repeated offset accumulates
    run_case("R11", 128'h9, 0, 1, 1, 2, 1,
             32'h012C_012C, 32'h0000_0000, 32'h00F0_000F, 32'h0000_0000);
    // R7 single error, unused upper half ignored
    run_case("R7", 128'hA, 0, 4, 1, 3, 0,
             32'h0020_0030, 32'h0040_0050, 32'h0066_0055, 32'h0077_0088);
    // R10 back-to-back pass after the previous ones
    run_case("R10", 128'hB, 0, 0, 1, 2, 3,
             32'h0009_0008, 32'h0207_0206, 32'h0001_0002, 32'h0004_0008);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule